// File: doc/BRIEF.md
# Multiplexer-Tree Programmable Logic Cell

This block is a small combinational logic cell made of three 2:1 multiplexers. Two first-level multiplexers each pick one of two data inputs under their own select line. A second-level multiplexer then picks between those two results. Its select is the OR of two separate join-select inputs.

Any Boolean function of a few variables can be formed by tying the eight cell inputs to constants or to signals. The tie pattern follows a Shannon expansion of the function.

The top module exposes two copies of the cell, and both work at the same time:

- **Raw cell.** Its eight inputs come straight from the ports, so any tie pattern can be applied.
- **Macro cell.** It sits behind a tie decoder. A code selects a named gate, and that gate is built from up to four variable inputs.

Top module: `mux_logic_cell`

## Requirements
- R1: With both join selects at 0, `rawF` equals `pathAHi` when `pathASel` is 1 and `pathALo` when `pathASel` is 0.
- R2: With `joinSelP` at 1, `rawF` equals `pathBHi` when `pathBSel` is 1 and `pathBLo` when `pathBSel` is 0.
- R3: The output stage takes the path-B result when `joinSelP` OR `joinSelQ` is 1, including when both are 1. Otherwise it takes the path-A result.
- R4: The raw and macro cells are independent. Changing any raw input leaves `macroF` unchanged, and changing the macro inputs leaves `rawF` unchanged.
- R5: Macro code 0 is an inverter: `macroF` = NOT `inX`.
- R6: Macro codes 1, 2 and 3 give, in that order:
  - code 1: `inX` (buffer);
  - code 2: `inX` AND `inY`;
  - code 3: `inX` OR `inY`.
- R7: Macro code 4 is a two-input NAND: `macroF` = NOT(`inX` AND `inY`). It is tied as path A high/high/select 1, path B low 1, high 0, select `inY`, `joinSelP` = `inX`, `joinSelQ` = 0.
- R8: Macro codes 5 and 6 are the gates with one inverted input:
  - code 5: `inX` AND NOT `inY`;
  - code 6: NOT `inX` AND `inY`, which is the same as a NOR with `inX` true and `inY` inverted.
- R9: Macro code 7 gives `inX` XOR `inY`.
- R10: Macro code 8 gives (`inX` AND `inY`) OR (NOT `inY` AND `inZ`) OR `inW`.
- R11: Macro codes 9 to 15 tie every cell input to 0, so `macroF` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pathALo | input | 1 | Raw cell, path A data when its select is 0 |
| pathAHi | input | 1 | Raw cell, path A data when its select is 1 |
| pathASel | input | 1 | Raw cell, path A select |
| pathBLo | input | 1 | Raw cell, path B data when its select is 0 |
| pathBHi | input | 1 | Raw cell, path B data when its select is 1 |
| pathBSel | input | 1 | Raw cell, path B select |
| joinSelP | input | 1 | Raw cell, first join select |
| joinSelQ | input | 1 | Raw cell, second join select |
| rawF | output | 1 | Raw cell output |
| macroSel | input | MODE_W | Macro code for the macro cell |
| inX | input | 1 | Macro variable X |
| inY | input | 1 | Macro variable Y |
| inZ | input | 1 | Macro variable Z |
| inW | input | 1 | Macro variable W |
| macroF | output | 1 | Macro cell output |

## Verification
The raw cell and the macro cell evaluate in the same cycle, so a fault that couples them would show only while both are being driven. The macro sweep provokes this by changing the raw inputs to a fresh pattern at every step, while each macro code walks through all of its variable combinations. In every such cycle, each output is judged against its own reference expression, computed in the bench from the requirement formulas.

// File: rtl/mux_cell_pkg.sv
package mux_cell_pkg;

  localparam int MACRO_W = 4;

  typedef struct packed {
    logic aLo;
    logic aHi;
    logic aSel;
    logic bLo;
    logic bHi;
    logic bSel;
    logic joinP;
    logic joinQ;
  } cellTies_t;

  typedef enum logic [MACRO_W-1:0] {
    MAC_INV   = 4'd0,
    MAC_BUF   = 4'd1,
    MAC_AND2  = 4'd2,
    MAC_OR2   = 4'd3,
    MAC_NAND2 = 4'd4,
    MAC_ANDNB = 4'd5,
    MAC_NORNA = 4'd6,
    MAC_XOR2  = 4'd7,
    MAC_SOP3  = 4'd8
  } macroCode_t;

  localparam cellTies_t TIES_ZERO = '0;

endpackage

// File: rtl/mux2_leaf.sv
module mux2_leaf #(
  parameter int W = 1
) (
  input  logic [W-1:0] inLo,
  input  logic [W-1:0] inHi,
  input  logic         sel,
  output logic [W-1:0] out
);
  assign out = sel ? inHi : inLo;
endmodule

// File: rtl/mux_tree_cell.sv
module mux_tree_cell
  import mux_cell_pkg::*;
(
  input  cellTies_t ties,
  output logic      f
);
  localparam int LEAVES = 2;

  logic [LEAVES-1:0] leafLo;
  logic [LEAVES-1:0] leafHi;
  logic [LEAVES-1:0] leafSel;
  logic [LEAVES-1:0] stageOut;
  logic              joinSel;

  assign leafLo  = {ties.bLo,  ties.aLo};
  assign leafHi  = {ties.bHi,  ties.aHi};
  assign leafSel = {ties.bSel, ties.aSel};

  genvar i;
  generate
    for (i = 0; i < LEAVES; i++) begin : g_leaf
      mux2_leaf #(.W(1)) u_leaf (
        .inLo (leafLo[i]),
        .inHi (leafHi[i]),
        .sel  (leafSel[i]),
        .out  (stageOut[i])
      );
    end
  endgenerate

  assign joinSel = ties.joinP | ties.joinQ;

  mux2_leaf #(.W(1)) u_join (
    .inLo (stageOut[0]),
    .inHi (stageOut[1]),
    .sel  (joinSel),
    .out  (f)
  );

  always_comb begin
    // R1
    if (ties.aSel) path_a_hi_chk: assert (stageOut[0] == ties.aHi);
    else           path_a_lo_chk: assert (stageOut[0] == ties.aLo);
    // R2
    if (ties.bSel) path_b_hi_chk: assert (stageOut[1] == ties.bHi);
    else           path_b_lo_chk: assert (stageOut[1] == ties.bLo);
    // R3
    if (ties.joinP || ties.joinQ) join_b_chk: assert (f == stageOut[1]);
    else                          join_a_chk: assert (f == stageOut[0]);
  end
endmodule

// File: rtl/macro_tie_ctrl.sv
module macro_tie_ctrl
  import mux_cell_pkg::*;
#(
  parameter int MODE_W = MACRO_W
) (
  input  logic [MODE_W-1:0] code,
  input  logic              x,
  input  logic              y,
  input  logic              z,
  input  logic              w,
  output cellTies_t         ties
);
  always_comb begin
    ties = TIES_ZERO;
    case (code)
      MAC_INV:   begin ties.aLo = 1'b1; ties.aSel = x; end
      MAC_BUF:   begin ties.aHi = 1'b1; ties.aSel = x; end
      MAC_AND2:  begin ties.aHi = y;    ties.aSel = x; end
      MAC_OR2:   begin ties.aLo = y;    ties.aHi = 1'b1; ties.aSel = x; end
      MAC_NAND2: begin
        ties.aLo = 1'b1; ties.aHi = 1'b1; ties.aSel = 1'b1;
        ties.bLo = 1'b1; ties.bSel = y;   ties.joinP = x;
      end
      MAC_ANDNB: begin ties.bLo = 1'b1; ties.bSel = y; ties.joinP = x; end
      MAC_NORNA: begin ties.aHi = 1'b1; ties.aSel = y; ties.joinP = x; end
      MAC_XOR2:  begin
        ties.aHi = 1'b1; ties.aSel = y;
        ties.bLo = 1'b1; ties.bSel = y; ties.joinP = x;
      end
      MAC_SOP3:  begin
        ties.aLo = w; ties.aHi = 1'b1; ties.aSel = z;
        ties.bLo = w; ties.bHi = 1'b1; ties.bSel = x; ties.joinQ = y;
      end
      default:   ties = TIES_ZERO;
    endcase
  end
endmodule

// File: rtl/mux_logic_cell.sv
module mux_logic_cell
  import mux_cell_pkg::*;
#(
  parameter int MODE_W = MACRO_W
) (
  input  logic              pathALo,
  input  logic              pathAHi,
  input  logic              pathASel,
  input  logic              pathBLo,
  input  logic              pathBHi,
  input  logic              pathBSel,
  input  logic              joinSelP,
  input  logic              joinSelQ,
  output logic              rawF,
  input  logic [MODE_W-1:0] macroSel,
  input  logic              inX,
  input  logic              inY,
  input  logic              inZ,
  input  logic              inW,
  output logic              macroF
);
  cellTies_t rawTies;
  cellTies_t macroTies;

  assign rawTies = '{aLo: pathALo, aHi: pathAHi, aSel: pathASel,
                     bLo: pathBLo, bHi: pathBHi, bSel: pathBSel,
                     joinP: joinSelP, joinQ: joinSelQ};

  mux_tree_cell u_rawCell (
    .ties (rawTies),
    .f    (rawF)
  );

  macro_tie_ctrl #(.MODE_W(MODE_W)) u_ctrl (
    .code (macroSel),
    .x    (inX),
    .y    (inY),
    .z    (inZ),
    .w    (inW),
    .ties (macroTies)
  );

  mux_tree_cell u_macroCell (
    .ties (macroTies),
    .f    (macroF)
  );

  always_comb begin
    // R5
    if (macroSel == MODE_W'(0)) inv_macro_chk: assert (macroF == !inX);
    // R6
    if (macroSel == MODE_W'(2)) and_macro_chk: assert (macroF == (inX && inY));
    // R7
    if (macroSel == MODE_W'(4)) nand_macro_chk: assert (macroF == !(inX && inY));
    // R9
    if (macroSel == MODE_W'(7)) xor_macro_chk: assert (macroF == (inX ^ inY));
    // R11
    if (macroSel > MODE_W'(8)) unused_code_chk: assert (macroF == 1'b0);
  end
endmodule

// File: tb/mux_logic_cell_test.sv
module mux_logic_cell_test;
  localparam int PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic pathALo, pathAHi, pathASel, pathBLo, pathBHi, pathBSel, joinSelP, joinSelQ;
  logic [3:0] macroSel;
  logic inX, inY, inZ, inW;
  logic rawF, macroF;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  mux_logic_cell uut (
    .pathALo(pathALo), .pathAHi(pathAHi), .pathASel(pathASel),
    .pathBLo(pathBLo), .pathBHi(pathBHi), .pathBSel(pathBSel),
    .joinSelP(joinSelP), .joinSelQ(joinSelQ), .rawF(rawF),
    .macroSel(macroSel), .inX(inX), .inY(inY), .inZ(inZ), .inW(inW),
    .macroF(macroF)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic driveRaw(input logic [7:0] v);
    {pathALo, pathAHi, pathASel, pathBLo, pathBHi, pathBSel, joinSelP, joinSelQ} = v;
  endtask

  function automatic logic rawRef(input logic [7:0] v);
    logic aOut, bOut;
    aOut = v[5] ? v[6] : v[7];
    bOut = v[2] ? v[3] : v[4];
    return (v[1] | v[0]) ? bOut : aOut;
  endfunction

  function automatic string rawTag(input logic [7:0] v);
    if (v[1] && v[0]) return "R3";
    if (v[1] || v[0]) return "R2";
    return "R1";
  endfunction

  function automatic logic macroRef(input int code, input logic x, y, z, w);
    case (code)
      0: return !x;
      1: return x;
      2: return x & y;
      3: return x | y;
      4: return !(x & y);
      5: return x & !y;
      6: return !x & y;
      7: return x ^ y;
      8: return (x & y) | (!y & z) | w;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string macroTag(input int code);
    case (code)
      0: return "R5";
      1, 2, 3: return "R6";
      4: return "R7";
      5, 6: return "R8";
      7: return "R9";
      8: return "R10";
      default: return "R11";
    endcase
  endfunction

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    driveRaw(8'h00);
    macroSel = 4'd0;
    {inX, inY, inZ, inW} = 4'b0000;
    repeat (2) @(negedge clk);
    check("R1 idle raw", rawF, 1'b0);
    check("R5 idle macro", macroF, 1'b1);
    rstN = 1'b1;

    for (int v = 0; v < 256; v++) begin
      @(posedge clk);
      driveRaw(v[7:0]);
      @(negedge clk);
      check(rawTag(v[7:0]), rawF, rawRef(v[7:0]));
    end

    for (int code = 0; code < 16; code++) begin
      for (int vv = 0; vv < 16; vv++) begin
        logic [7:0] rp;
        rp = 8'((code * 16 + vv) * 37 + 11);
        @(posedge clk);
        macroSel = code[3:0];
        {inX, inY, inZ, inW} = vv[3:0];
        driveRaw(rp);
        @(negedge clk);
        check(macroTag(code), macroF, macroRef(code, inX, inY, inZ, inW));
        check("R4 raw beside macro", rawF, rawRef(rp));
      end
      @(posedge clk);
      driveRaw(~8'((code * 16) * 37 + 11));
      @(negedge clk);
      check("R4 macro held", macroF, macroRef(code, inX, inY, inZ, inW));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule